// File: doc/BRIEF.md
# Power Stage Fault Flag Controller

This block merges the digitised protection inputs of a synchronous buck power stage into one shared fault pin and one driver-disable request. Each fault source has its own set and clear rule. A shorted high-side device and over-current are judged once per PWM cycle, with counts kept in PWM cycles. Over-temperature uses a hysteresis band on an 8-bit Celsius code. Supply undervoltage passes through a glitch filter counted in system clocks.

The fault pin has three levels. It can be driven high, released, or weakly pulled low. The weak-low level marks undervoltage and outranks every other state. Phase and over-current faults raise the pin but let switching continue. Over-temperature and undervoltage also stop the driver. Undervoltage additionally clamps the current report to its reference.

Top module: `pwrstage_fault_flag`

## Requirements
- R1: Synchronous active-low reset clears all counters and flags, so `flt_drive` = 2'b00 (released), `drv_off` = 0 and `iout_clamp` = 0.
- R2: A clock with `pwm_rise` = 1, `ls_on` = 1 and `sw_hi` = 1 is a phase-faulted cycle. On the clock of the 7th consecutive faulted cycle, the phase condition becomes set, and `flt_drive` reads 2'b01 one clock after that strobe.
- R3: A `pwm_rise` strobe without the phase condition clears the phase accumulator and the phase condition on that clock.
- R4: An over-current event is a `pwm_fall` strobe where `oc_trip` was high on any clock since the previous `pwm_fall`, that strobe's clock included. The over-current condition sets on the 10th consecutive such event.
- R5: A `pwm_fall` with no over-current resets the event accumulator. The over-current condition clears on the 3rd consecutive clean `pwm_fall`, and any faulted `pwm_fall` restarts that clean count.
- R6: Phase and over-current conditions never raise `drv_off`.
- R7: `temp_code` > 140 sets the over-temperature condition on the next clock. That condition raises both `flt_drive` (2'b01) and `drv_off`. It holds while 120 <= `temp_code` <= 140 and clears when `temp_code` < 120.
- R8: Undervoltage (`vcc_uv` or `vdrv_uv`) becomes active only after the raw condition has been high for 16 consecutive clocks. A shorter pulse has no effect on any output.
- R9: Active undervoltage drives `flt_drive` = 2'b10 (weak low) and sets `drv_off` = 1 and `iout_clamp` = 1. It is released on the clock after both supplies read good.
- R10: `flt_drive` is 2'b10 whenever undervoltage is active, whatever the other conditions. Otherwise it is 2'b01 if any of the over-temperature, phase or over-current conditions is set, and 2'b00 if none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_rise | input | 1 | One-clock strobe at a PWM low-to-high transition |
| pwm_fall | input | 1 | One-clock strobe at a PWM high-to-low transition |
| ls_on | input | 1 | Low-side device still conducting |
| sw_hi | input | 1 | Switch node above the short threshold |
| oc_trip | input | 1 | Over-current comparator output |
| temp_code | input | 8 | Die temperature in degrees Celsius |
| vcc_uv | input | 1 | Logic supply undervoltage comparator |
| vdrv_uv | input | 1 | Driver supply undervoltage comparator |
| flt_drive | output | 2 | Fault pin level: 00 released, 01 high, 10 weak low |
| drv_off | output | 1 | Request both power devices off |
| iout_clamp | output | 1 | Short current report to its reference |

## Verification
Properties checked on every clock:
- An over-temperature code stops the driver on the next clock.
- The temperature condition stays stable inside the hysteresis band.
- A clean rising strobe drops the phase condition.
- The phase and over-current conditions rise only on their own strobes.
- Undervoltage outranks all other states and releases as soon as both supplies are good.
- A phase or over-current fault never stops the driver.

The counted behaviours can be shown only by the bench scenarios, run against an independent cycle model:
- the exact 7th phase cycle and 10th over-current event;
- the three-clean-cycle release and its restart;
- the 15-versus-16-clock glitch filter;
- the band edges at 140 and 119.

// File: rtl/pwrstage_fault_flag.sv
`timescale 1ns/1ps
module pwrstage_fault_flag #(
  parameter int TEMP_W    = 8,
  parameter int PH_CYCLES = 7,
  parameter int OC_EVENTS = 10,
  parameter int OC_CLEAN  = 3,
  parameter int OT_SET    = 140,
  parameter int OT_CLR    = 120,
  parameter int UV_FILT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_rise,
  input  logic              pwm_fall,
  input  logic              ls_on,
  input  logic              sw_hi,
  input  logic              oc_trip,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              vcc_uv,
  input  logic              vdrv_uv,
  output logic [1:0]        flt_drive,
  output logic              drv_off,
  output logic              iout_clamp
);
  localparam int PH_W = $clog2(PH_CYCLES);
  localparam int OC_W = $clog2(OC_EVENTS);
  localparam int CL_W = $clog2(OC_CLEAN);
  localparam int UV_W = $clog2(UV_FILT);

  logic [PH_W-1:0] ph_cnt;
  logic [OC_W-1:0] oc_cnt;
  logic [CL_W-1:0] cl_cnt;
  logic [UV_W-1:0] uv_cnt;
  logic ph_q, oc_q, ot_q, uv_q, oc_seen;

  wire ph_hit = ls_on & sw_hi;
  wire oc_hit = oc_seen | oc_trip;
  wire uv_raw = vcc_uv | vdrv_uv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_cnt <= '0;
      ph_q   <= 1'b0;
    end else if (pwm_rise) begin
      if (!ph_hit) begin
        ph_cnt <= '0;
        ph_q   <= 1'b0;
      end else if (ph_cnt == PH_W'(PH_CYCLES-1)) begin
        ph_q   <= 1'b1;
      end else begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_seen <= 1'b0;
      oc_cnt  <= '0;
      cl_cnt  <= '0;
      oc_q    <= 1'b0;
    end else begin
      oc_seen <= pwm_fall ? 1'b0 : oc_hit;
      if (pwm_fall) begin
        if (oc_hit) begin
          cl_cnt <= '0;
          if (oc_cnt == OC_W'(OC_EVENTS-1)) oc_q <= 1'b1;
          else oc_cnt <= oc_cnt + 1'b1;
        end else begin
          oc_cnt <= '0;
          if (cl_cnt == CL_W'(OC_CLEAN-1)) oc_q <= 1'b0;
          else cl_cnt <= cl_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          ot_q <= 1'b0;
    else if (temp_code > TEMP_W'(OT_SET)) ot_q <= 1'b1;
    else if (temp_code < TEMP_W'(OT_CLR)) ot_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !uv_raw) begin
      uv_cnt <= '0;
      uv_q   <= 1'b0;
    end else if (uv_cnt == UV_W'(UV_FILT-1)) begin
      uv_q   <= 1'b1;
    end else begin
      uv_cnt <= uv_cnt + 1'b1;
    end
  end

  assign flt_drive  = uv_q ? 2'b10 : ((ot_q | ph_q | oc_q) ? 2'b01 : 2'b00);
  assign drv_off    = ot_q | uv_q;
  assign iout_clamp = uv_q;
endmodule

module pwrstage_fault_flag_chk #(
  parameter int TEMP_W = 8,
  parameter int OT_SET = 140,
  parameter int OT_CLR = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_rise,
  input logic              pwm_fall,
  input logic              ls_on,
  input logic              sw_hi,
  input logic [TEMP_W-1:0] temp_code,
  input logic              vcc_uv,
  input logic              vdrv_uv,
  input logic [1:0]        flt_drive,
  input logic              drv_off,
  input logic              iout_clamp,
  input logic              ph_q,
  input logic              oc_q,
  input logic              ot_q
);
  assert_ot_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > TEMP_W'(OT_SET)) |=> drv_off);
  assert_ot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TEMP_W'(OT_CLR) && temp_code <= TEMP_W'(OT_SET)) |=> $stable(ot_q));
  assert_ph_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_rise && !(ls_on && sw_hi)) |=> !ph_q);
  assert_ph_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_q) |-> $past(pwm_rise && ls_on && sw_hi));
  assert_oc_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_q) |-> $past(pwm_fall));
  assert_no_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ot_q && temp_code <= TEMP_W'(OT_SET) && !(vcc_uv || vdrv_uv)) |=> !drv_off);
  assert_uv_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vcc_uv || vdrv_uv) |=> (!iout_clamp && flt_drive != 2'b10));
  assert_uv_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iout_clamp |-> (flt_drive == 2'b10 && drv_off));
endmodule

bind pwrstage_fault_flag pwrstage_fault_flag_chk #(
  .TEMP_W(TEMP_W), .OT_SET(OT_SET), .OT_CLR(OT_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_rise(pwm_rise), .pwm_fall(pwm_fall),
  .ls_on(ls_on), .sw_hi(sw_hi), .temp_code(temp_code), .vcc_uv(vcc_uv),
  .vdrv_uv(vdrv_uv), .flt_drive(flt_drive), .drv_off(drv_off),
  .iout_clamp(iout_clamp), .ph_q(ph_q), .oc_q(oc_q), .ot_q(ot_q)
);

// File: tb/pwrstage_fault_flag_tb.sv
`timescale 1ns/1ps
module pwrstage_fault_flag_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pwm_rise, pwm_fall, ls_on, sw_hi, oc_trip, vcc_uv, vdrv_uv;
  logic [7:0] temp_code;
  logic [1:0] flt_drive;
  logic drv_off, iout_clamp;
  int checks = 0, errors = 0;

  pwrstage_fault_flag u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_rise(pwm_rise), .pwm_fall(pwm_fall),
    .ls_on(ls_on), .sw_hi(sw_hi), .oc_trip(oc_trip), .temp_code(temp_code),
    .vcc_uv(vcc_uv), .vdrv_uv(vdrv_uv), .flt_drive(flt_drive),
    .drv_off(drv_off), .iout_clamp(iout_clamp)
  );

  int m_ph_cnt, m_oc_cnt, m_cl_cnt, m_uv_cnt;
  bit m_ph, m_oc, m_ot, m_uv, m_seen;

  function automatic logic [3:0] exp_out();
    logic [1:0] f;
    f = m_uv ? 2'b10 : ((m_ot || m_ph || m_oc) ? 2'b01 : 2'b00);
    return {f, m_ot | m_uv, m_uv};
  endfunction

  task automatic model_tick();
    bit hit;
    if (!rst_n) begin
      m_ph_cnt = 0; m_oc_cnt = 0; m_cl_cnt = 0; m_uv_cnt = 0;
      m_ph = 0; m_oc = 0; m_ot = 0; m_uv = 0; m_seen = 0;
      return;
    end
    if (pwm_rise) begin
      if (!(ls_on && sw_hi)) begin m_ph_cnt = 0; m_ph = 0; end
      else if (m_ph_cnt == 6) m_ph = 1;
      else m_ph_cnt++;
    end
    hit = m_seen || oc_trip;
    m_seen = pwm_fall ? 0 : hit;
    if (pwm_fall) begin
      if (hit) begin
        m_cl_cnt = 0;
        if (m_oc_cnt == 9) m_oc = 1; else m_oc_cnt++;
      end else begin
        m_oc_cnt = 0;
        if (m_cl_cnt == 2) m_oc = 0; else m_cl_cnt++;
      end
    end
    if (temp_code > 140) m_ot = 1;
    else if (temp_code < 120) m_ot = 0;
    if (!(vcc_uv || vdrv_uv)) begin m_uv_cnt = 0; m_uv = 0; end
    else if (m_uv_cnt == 15) m_uv = 1;
    else m_uv_cnt++;
  endtask

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_tick();
    #2;
    check(tag, {flt_drive, drv_off, iout_clamp}, exp_out());
  endtask

  task automatic rise_cyc(bit f);
    pwm_rise = 1; ls_on = f; sw_hi = f; step("R2");
    pwm_rise = 0; ls_on = 0; sw_hi = 0; step("R2");
  endtask

  task automatic fall_cyc(bit f);
    oc_trip = f; pwm_fall = 1; step("R4");
    oc_trip = 0; pwm_fall = 0; step("R4");
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int uv_hold;
    void'($urandom(32'd4711));
    rst_n = 0; pwm_rise = 0; pwm_fall = 0; ls_on = 0; sw_hi = 0;
    oc_trip = 0; vcc_uv = 0; vdrv_uv = 0; temp_code = 8'd60;
    repeat (3) step("R1");
    check("R1", {flt_drive, drv_off, iout_clamp}, 4'b0000);
    rst_n = 1;

    for (int i = 0; i < 6; i++) rise_cyc(1);
    check("R2", {2'b00, flt_drive}, 4'b0000);
    rise_cyc(1);
    check("R2", {2'b00, flt_drive}, 4'b0001);
    check("R6", {3'b000, drv_off}, 4'b0000);
    rise_cyc(0);
    check("R3", {2'b00, flt_drive}, 4'b0000);

    for (int i = 0; i < 9; i++) fall_cyc(1);
    fall_cyc(0);
    for (int i = 0; i < 9; i++) fall_cyc(1);
    check("R5", {2'b00, flt_drive}, 4'b0000);
    fall_cyc(1);
    check("R4", {2'b00, flt_drive}, 4'b0001);
    check("R6", {3'b000, drv_off}, 4'b0000);
    fall_cyc(0); fall_cyc(0);
    check("R5", {2'b00, flt_drive}, 4'b0001);
    fall_cyc(1);
    fall_cyc(0); fall_cyc(0);
    check("R5", {2'b00, flt_drive}, 4'b0001);
    fall_cyc(0);
    check("R5", {2'b00, flt_drive}, 4'b0000);

    temp_code = 8'd140; step("R7");
    check("R7", {flt_drive, drv_off, 1'b0}, 4'b0000);
    temp_code = 8'd141; step("R7");
    check("R7", {flt_drive, drv_off, 1'b0}, 4'b0110);
    temp_code = 8'd120; step("R7");
    check("R7", {flt_drive, drv_off, 1'b0}, 4'b0110);
    temp_code = 8'd119; step("R7");
    check("R7", {flt_drive, drv_off, 1'b0}, 4'b0000);

    vcc_uv = 1;
    for (int i = 0; i < 15; i++) step("R8");
    check("R8", {flt_drive, drv_off, iout_clamp}, 4'b0000);
    vcc_uv = 0; step("R8");
    vcc_uv = 1; temp_code = 8'd150;
    for (int i = 0; i < 16; i++) step("R8");
    check("R8", {flt_drive, drv_off, iout_clamp}, 4'b1011);
    vdrv_uv = 1; step("R9");
    vcc_uv = 0; step("R9");
    check("R9", {flt_drive, drv_off, iout_clamp}, 4'b1011);
    vdrv_uv = 0; step("R9");
    check("R10", {flt_drive, drv_off, iout_clamp}, 4'b0110);
    temp_code = 8'd100; step("R10");
    check("R10", {flt_drive, drv_off, iout_clamp}, 4'b0000);

    uv_hold = 0;
    for (int i = 0; i < 6000; i++) begin
      pwm_rise = ($urandom % 4) == 0;
      pwm_fall = ($urandom % 4) == 0;
      ls_on    = ($urandom % 8) != 0;
      sw_hi    = ($urandom % 6) != 0;
      oc_trip  = ($urandom % 3) == 0;
      if (($urandom % 50) == 0) temp_code = 8'(105 + $urandom % 50);
      if (uv_hold > 0) uv_hold--;
      else if (($urandom % 150) == 0) uv_hold = 8 + $urandom % 24;
      vcc_uv  = (uv_hold > 0) && ($urandom % 2 == 0 || uv_hold > 4);
      vdrv_uv = (uv_hold > 0) && !vcc_uv;
      step("R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule